// File: doc/BRIEF.md
# General-Purpose I/O Port

This block controls a bank of general-purpose pins from a simple synchronous register bus. Each pin has three registers. A direction bit makes the pin an input or an output. An output latch bit holds the value to drive. A port view shows the level sampled on the pin. Software reads and writes these registers over a bus with address, write enable, write data and read data. Read data is combinational from the address.

Pin inputs pass through a two-stage synchroniser before the port view shows them. A write to the port view does not create separate storage: it lands in the output latch. The latch view always reads back the stored drive value. A read-modify-write sequence on the latch view therefore never picks up the sampled pin levels.

Each pin also has a peripheral-enable input. When it is high, the pin is owned by an alternate function, and the GPIO output enable for that pin is released.

Top module: `gpio_port`

## Requirements
- R1: After reset every direction bit is 1 (input), every latch bit is 0, and every bit of `pinOe` and `pinOut` is 0.
- R2: A bus write with `addr` = 0 loads `wrData` into the direction register at the next rising edge. A read with `addr` = 0 returns that register. Bit value 1 means input and 0 means output.
- R3: A bus write with `addr` = 1 loads `wrData` into the output latch at the next rising edge. A read with `addr` = 1 returns the latch contents.
- R4: A bus write with `addr` = 2 loads `wrData` into the output latch at the next rising edge and leaves the direction register unchanged.
- R5: A read with `addr` = 2 returns `pinIn` delayed by two rising edges. A change of `pinIn` is not visible after one edge and is visible after the second.
- R6: The value read with `addr` = 1 does not depend on `pinIn`.
- R7: `pinOut` equals the output latch bit for every pin.
- R8: `pinOe[i]` is 1 exactly when direction bit i is 0 and `periphEn[i]` is 0.
- R9: Addresses other than 0, 1 and 2 read as zero. Writes to them change neither the direction register nor the latch.
- R10: While `wrEn` is low, no register changes, whatever `addr` and `wrData` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | NUM_PINS | Write data |
| rdData | output | NUM_PINS | Read data of the addressed register |
| pinIn | input | NUM_PINS | Level sampled at each pin |
| pinOut | output | NUM_PINS | Drive value for each pin |
| pinOe | output | NUM_PINS | Output enable for each pin |
| periphEn | input | NUM_PINS | Per-pin hand-over to the alternate function |

## Verification
Two functions can fall in the same cycle: a bus write to the port view and a change on `pinIn`. The bench provokes this by writing the port address at the same edge where a new pin pattern is applied. It then judges the two results separately. The latch view and `pinOut` must hold the written word, and two edges later the port view must hold the new pin pattern, not the written word. A second overlap comes from changing `periphEn` while pins are set as outputs. Here the output enables must fall at once, while the latch keeps its value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register offsets; the bus decode depends on these values
  localparam int OFS_DIR  = 0;
  localparam int OFS_LAT  = 1;
  localparam int OFS_PORT = 2;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_PORT = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrDir;
    logic    wrLat;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= dIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobe_t       strobe
);

  regSel_e sel;

  always_comb begin
    if (addr == ADDR_W'(OFS_DIR))       sel = SEL_DIR;
    else if (addr == ADDR_W'(OFS_LAT))  sel = SEL_LAT;
    else if (addr == ADDR_W'(OFS_PORT)) sel = SEL_PORT;
    else                                sel = SEL_NONE;
  end

  always_comb begin
    strobe.rdSel = sel;
    strobe.wrDir = wrEn && (sel == SEL_DIR);
    // port-view writes alias onto the latch
    strobe.wrLat = wrEn && ((sel == SEL_LAT) || (sel == SEL_PORT));
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] periphEn,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);

  logic [NUM_PINS-1:0] dirQ;
  logic [NUM_PINS-1:0] latQ;
  logic [NUM_PINS-1:0] pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dirQ <= '1;
    else if (strobe.wrDir) dirQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latQ <= '0;
    else if (strobe.wrLat) latQ <= wrData;
  end

  gpio_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .dIn (pinIn),
    .dOut(pinSync)
  );

  always_comb begin
    case (strobe.rdSel)
      SEL_DIR:  rdData = dirQ;
      SEL_LAT:  rdData = latQ;
      SEL_PORT: rdData = pinSync;
      default:  rdData = '0;
    endcase
  end

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
      assign pinOut[p] = latQ[p];
      assign pinOe[p]  = ~dirQ[p] & ~periphEn[p];
    end
  endgenerate

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  input  logic [NUM_PINS-1:0] periphEn
);

  ctrlStrobe_t strobe;

  gpio_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn  (wrEn),
    .addr  (addr),
    .strobe(strobe)
  );

  gpio_datapath #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .pinIn   (pinIn),
    .periphEn(periphEn),
    .rdData  (rdData),
    .pinOut  (pinOut),
    .pinOe   (pinOe)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   addr,
  input logic                wrEn,
  input logic [NUM_PINS-1:0] wrData,
  input logic [NUM_PINS-1:0] rdData,
  input logic [NUM_PINS-1:0] pinIn,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic [NUM_PINS-1:0] periphEn
);

  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LAT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(2);

  logic [1:0] liveCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              liveCnt <= '0;
    else if (liveCnt != 2'd2) liveCnt <= liveCnt + 2'd1;
  end

  logic unmapped;
  assign unmapped = (addr != A_DIR) && (addr != A_LAT) && (addr != A_PORT);

  AST_OE_PERIPH: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & periphEn) == '0); // R8

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_DIR) |=> (pinOe == (~$past(wrData) & ~periphEn))); // R2

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == A_LAT || addr == A_PORT)) |=> (pinOut == $past(wrData))); // R4

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(pinOut)); // R10

  AST_PORT_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (liveCnt == 2'd2 && addr == A_PORT) |-> (rdData == $past(pinIn, 2))); // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |-> (rdData == '0)); // R9

endmodule

bind gpio_port gpio_port_chk #(
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .addr    (addr),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .pinIn   (pinIn),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .periphEn(periphEn)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;

  localparam int NP = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wrEn = 1'b0;
  logic [NP-1:0] wrData = '0;
  logic [NP-1:0] rdData;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut;
  logic [NP-1:0] pinOe;
  logic [NP-1:0] periphEn = '0;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port #(.NUM_PINS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .periphEn(periphEn)
  );

  task automatic check(input string req, input logic [NP-1:0] act,
                       input logic [NP-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic tReset();
    logic [NP-1:0] v;
    busRead(0, v); check("R1 dir reset", v, '1);
    busRead(1, v); check("R1 latch reset", v, '0);
    check("R1 oe reset", pinOe, '0);
    check("R1 out reset", pinOut, '0);
  endtask

  task automatic tDir();
    logic [NP-1:0] v;
    busWrite(0, 16'hFF0F);
    busRead(0, v); check("R2 dir readback", v, 16'hFF0F);
    check("R8 oe from dir", pinOe, 16'h00F0);
  endtask

  task automatic tLatch();
    logic [NP-1:0] v;
    busWrite(1, 16'hA5C3);
    busRead(1, v); check("R3 latch readback", v, 16'hA5C3);
    check("R7 pinOut follows latch", pinOut, 16'hA5C3);
  endtask

  task automatic tPortWrite();
    logic [NP-1:0] v;
    busWrite(2, 16'h1234);
    busRead(1, v); check("R4 port write to latch", v, 16'h1234);
    busRead(0, v); check("R4 dir untouched", v, 16'hFF0F);
  endtask

  task automatic tSync();
    @(negedge clk);
    pinIn = 16'hBEEF; addr = 2;
    @(negedge clk); #1;
    check("R5 not yet after one edge", rdData, 16'h0000);
    @(negedge clk); #1;
    check("R5 visible after two edges", rdData, 16'hBEEF);
  endtask

  task automatic tLatchIndep();
    logic [NP-1:0] v;
    busWrite(1, 16'h0F0F);
    @(negedge clk); pinIn = 16'hF0F0;
    repeat (3) @(negedge clk);
    busRead(1, v); check("R6 latch ignores pins", v, 16'h0F0F);
    busRead(2, v); check("R5 port shows pins", v, 16'hF0F0);
  endtask

  task automatic tPeriph();
    @(negedge clk); periphEn = 16'h00F0; #1;
    check("R8 periph releases all", pinOe, 16'h0000);
    @(negedge clk); periphEn = 16'h0030; #1;
    check("R8 periph partial", pinOe, 16'h00C0);
    check("R7 latch kept under periph", pinOut, 16'h0F0F);
    @(negedge clk); periphEn = '0;
  endtask

  task automatic tUnmapped();
    logic [NP-1:0] v;
    busWrite(3, 16'hFFFF);
    busWrite(7, 16'h5555);
    busRead(3, v); check("R9 unmapped reads zero", v, '0);
    busRead(15, v); check("R9 high unmapped reads zero", v, '0);
    busRead(0, v); check("R9 dir unchanged", v, 16'hFF0F);
    busRead(1, v); check("R9 latch unchanged", v, 16'h0F0F);
  endtask

  task automatic tNoWrite();
    logic [NP-1:0] v;
    @(negedge clk); addr = 1; wrData = 16'hDEAD; wrEn = 1'b0;
    @(negedge clk); addr = 0;
    @(negedge clk);
    busRead(1, v); check("R10 latch held", v, 16'h0F0F);
    busRead(0, v); check("R10 dir held", v, 16'hFF0F);
  endtask

  task automatic tCollide();
    logic [NP-1:0] v;
    @(negedge clk);
    addr = 2; wrData = 16'h6789; wrEn = 1'b1; pinIn = 16'h3C3C;
    @(negedge clk); wrEn = 1'b0; #1;
    check("R4 collide latch", pinOut, 16'h6789);
    @(negedge clk); #1;
    check("R5 collide port shows pins", rdData, 16'h3C3C);
    busRead(1, v); check("R3 collide latch view", v, 16'h6789);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tDir();
    tLatch();
    tPortWrite();
    tSync();
    tLatchIndep();
    tPeriph();
    tUnmapped();
    tNoWrite();
    tCollide();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule